// File: doc/BRIEF.md
# VLIW Packet Framer and Expander

This block sits between an instruction fetch stream and a VLIW decoder. It accepts 32-bit instruction words one per cycle and gathers them into a single execution packet. The two parse bits in each word tell the block where the packet ends. While it gathers the packet, it expands each word into a list of instruction entries. A duplex word becomes two sub-instruction entries. A constant-extender word produces no entry of its own: it widens the immediate of the entry that follows it. When the packet closes, the block may add a hardware-loop-end entry, which it derives from the parse bits of the first words.

A packet closes on an end word, which is either a word with parse bits `11` or a duplex word. Closing produces a one-cycle `pkt_done` pulse together with a status, the word count, the byte size and the entry list. A packet that never reaches an end word is reported as short, with zero words and zero entries. This happens when the stream is flushed, or when `MAX_WORDS` words arrive without an end word. Opcode decoding is left to the next stage.

Top module: `vliw_pkt_framer`

## Requirements
- R1: A word accepted with `in_valid` high and parse bits [15:14] = `11` closes the packet. In the following cycle `pkt_done` is high for exactly one cycle, `pkt_words` equals the number of words accepted since the previous packet closed, and `pkt_bytes` equals four times `pkt_words`.
- R2: A word with parse bits `00` is a duplex word, and it also closes the packet. It yields two entries of kind 1 (sub-instruction). The first entry holds bits [28:16] of the word, zero-extended. The second holds bits [12:0], zero-extended.
- R3: The duplex class is formed as {bits [31:29], bit 13}. A duplex word whose class is 4'hF gives status 3 (fault).
- R4: A word with parse bits other than `00` and bits [31:28] = 0 is an extender. It adds no entry. The next entry produced in the same packet has its extended flag set and the immediate {w[27:16], w[13:0], 6'b0} OR its own bits [5:0]. A pending extension does not carry over into the next packet.
- R5: Any other word yields one entry of kind 0 whose encoding is the raw word. Every entry that is not extended has an immediate equal to its own bits [5:0], zero-extended, and a clear extended flag.
- R6: In a packet of exactly two words, if word 0 has parse bits `10`, an entry of kind 2 with encoding 1 (end of loop 0) is appended last.
- R7: In a packet of three or more words, a kind-2 entry is appended last whose encoding has bit 0 set if word 0 has parse bits `10` and bit 1 set if word 1 has parse bits `10`. No entry is appended when both bits are clear.
- R8: A packet is reported with status 2 (short), `pkt_words` = 0 and `pkt_count` = 0 when either of these occurs:
  - `in_flush` is high and `in_valid` is low while a packet is open;
  - the `MAX_WORDS`-th word of a packet is not an end word.
- R9: If a packet would hold more than `MAX_ENT` entries, loop entry included, its status is 3 and `pkt_count` is `MAX_ENT`. A packet that closes without a reserved class or an overflow has status 1 (ok), and `pkt_count` equals its entry count.
- R10: After a synchronous reset, `pkt_done` is 0 and `pkt_status` is 0 (idle).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | `in_word` is presented this cycle |
| in_word | input | 32 | Instruction word |
| in_flush | input | 1 | Stream exhausted; considered only while `in_valid` is low |
| pkt_done | output | 1 | One-cycle pulse when a packet closes |
| pkt_status | output | 2 | 0 idle, 1 ok, 2 short, 3 fault |
| pkt_words | output | $clog2(MAX_WORDS+1) | Words consumed by the packet |
| pkt_bytes | output | $clog2(MAX_WORDS+1)+2 | Packet size in bytes |
| pkt_count | output | $clog2(MAX_ENT+1) | Number of valid entries |
| ent_enc | output | MAX_ENT*32 | Entry encodings, entry i at [32i+31:32i] |
| ent_kind | output | MAX_ENT*2 | Entry kinds: 0 plain, 1 sub-instruction, 2 loop end |
| ent_ext | output | MAX_ENT | Entry extended flags |
| ent_imm | output | MAX_ENT*32 | Final immediates |

## Verification
Two situations are the hardest to reach from the ports:
- A loop-end entry that has to be appended to a list that is already full. Getting there takes four words with a loop-end marker on word 1 and plain words around it, so the loop entry is the fifth entry.
- An extender placed directly before a duplex, so that the extension must land on the first sub-instruction and not the second.

The bench builds both from directed word sequences with a small `MAX_ENT`. It then runs a long stretch of random words and random flushes. That stretch reaches the word-limit cutoff and back-to-back single-word packets, and a queue-based model that reprocesses each packet's whole word list checks every one.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

    typedef enum logic [1:0] {
        ENT_PLAIN = 2'd0,
        ENT_SUB   = 2'd1,
        ENT_LOOP  = 2'd2
    } ent_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OK    = 2'd1,
        ST_SHORT = 2'd2,
        ST_FAULT = 2'd3
    } pkt_status_e;

    typedef struct packed {
        logic [31:0] enc;
        ent_kind_e   kind;
        logic        ext;
        logic [31:0] imm;
    } entry_t;

    localparam logic [1:0] PB_DUPLEX  = 2'b00;
    localparam logic [1:0] PB_LOOPEND = 2'b10;
    localparam logic [1:0] PB_LAST    = 2'b11;
    localparam logic [3:0] CLASS_RSVD = 4'hF;
    localparam int         OWN_IMM_W  = 6;

    function automatic logic [1:0] parse_of(input logic [31:0] w);
        return w[15:14];
    endfunction

    function automatic logic [3:0] dup_class(input logic [31:0] w);
        return {w[31:29], w[13]};
    endfunction

    function automatic logic is_extender(input logic [31:0] w);
        return (w[15:14] != PB_DUPLEX) && (w[31:28] == 4'h0);
    endfunction

    function automatic logic [31:0] ext_payload(input logic [31:0] w);
        return {w[27:16], w[13:0], {OWN_IMM_W{1'b0}}};
    endfunction

    function automatic logic [31:0] final_imm(input logic [31:0] enc,
                                              input logic        ext_on,
                                              input logic [31:0] pay);
        logic [31:0] own;
        own = {{(32-OWN_IMM_W){1'b0}}, enc[OWN_IMM_W-1:0]};
        return ext_on ? (pay | own) : own;
    endfunction

endpackage

// File: rtl/pfx_word_split.sv
module pfx_word_split
    import pfx_pkg::*;
(
    input  logic [31:0] word,
    input  logic        ext_on,
    input  logic [31:0] ext_pay,
    output logic [1:0]  n_new,
    output entry_t      ent_a,
    output entry_t      ent_b,
    output logic        is_end,
    output logic        is_ext,
    output logic        reserved,
    output logic        loop_mark,
    output logic [31:0] pay
);
    logic [1:0]  pb;
    logic        dup;
    logic [31:0] sub_hi;
    logic [31:0] sub_lo;

    always_comb begin
        pb        = parse_of(word);
        dup       = (pb == PB_DUPLEX);
        is_ext    = is_extender(word);
        is_end    = dup || (pb == PB_LAST);
        loop_mark = (pb == PB_LOOPEND);
        reserved  = dup && (dup_class(word) == CLASS_RSVD);
        pay       = ext_payload(word);
        sub_hi    = {19'd0, word[28:16]};
        sub_lo    = {19'd0, word[12:0]};
        ent_a     = '0;
        ent_b     = '0;
        n_new     = 2'd0;
        if (dup) begin
            n_new      = 2'd2;
            ent_a.enc  = sub_hi;
            ent_a.kind = ENT_SUB;
            ent_a.ext  = ext_on;
            ent_a.imm  = final_imm(sub_hi, ext_on, ext_pay);
            ent_b.enc  = sub_lo;
            ent_b.kind = ENT_SUB;
            ent_b.ext  = 1'b0;
            ent_b.imm  = final_imm(sub_lo, 1'b0, ext_pay);
        end else if (!is_ext) begin
            n_new      = 2'd1;
            ent_a.enc  = word;
            ent_a.kind = ENT_PLAIN;
            ent_a.ext  = ext_on;
            ent_a.imm  = final_imm(word, ext_on, ext_pay);
        end
    end
endmodule

// File: rtl/pfx_loop_infer.sv
module pfx_loop_infer #(
    parameter int WW = 3
) (
    input  logic [WW-1:0] total_words,
    input  logic          w0_mark,
    input  logic          w1_mark,
    output logic [1:0]    code
);
    always_comb begin
        code = 2'b00;
        if (total_words == WW'(2))
            code = {1'b0, w0_mark};
        else if (total_words >= WW'(3))
            code = {w1_mark, w0_mark};
    end
endmodule

// File: rtl/pfx_entry_bank.sv
module pfx_entry_bank
    import pfx_pkg::*;
#(
    parameter int N     = 8,
    parameter int IW    = 4,
    parameter int PORTS = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we    [PORTS],
    input  logic [IW-1:0] widx  [PORTS],
    input  entry_t        wdata [PORTS],
    output entry_t        q     [N]
);
    entry_t nxt [N];

    always_comb begin
        for (int i = 0; i < N; i++) begin
            nxt[i] = q[i];
            for (int k = 0; k < PORTS; k++)
                if (we[k] && (widx[k] == IW'(i)))
                    nxt[i] = wdata[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) q[i] <= '0;
        end else begin
            q <= nxt;
        end
    end
endmodule

// File: rtl/vliw_pkt_framer.sv
module vliw_pkt_framer
    import pfx_pkg::*;
#(
    parameter int MAX_ENT   = 8,
    parameter int MAX_WORDS = 4,
    localparam int WW = $clog2(MAX_WORDS + 1),
    localparam int CW = $clog2(MAX_ENT + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [31:0]           in_word,
    input  logic                  in_flush,
    output logic                  pkt_done,
    output logic [1:0]            pkt_status,
    output logic [WW-1:0]         pkt_words,
    output logic [WW+1:0]         pkt_bytes,
    output logic [CW-1:0]         pkt_count,
    output logic [MAX_ENT*32-1:0] ent_enc,
    output logic [MAX_ENT*2-1:0]  ent_kind,
    output logic [MAX_ENT-1:0]    ent_ext,
    output logic [MAX_ENT*32-1:0] ent_imm
);
    localparam int IW    = $clog2(MAX_ENT + MAX_WORDS + 4);
    localparam int PORTS = 3;

    logic          open_q, ext_q, err_q, w0m_q, w1m_q;
    logic [WW-1:0] words_q;
    logic [IW-1:0] cnt_q;
    logic [31:0]   pay_q;

    logic [WW-1:0] base_words, total_words;
    logic [IW-1:0] base_cnt, need;
    logic          base_ext, base_err;

    logic [1:0]  n_new, loop_code;
    entry_t      ent_a, ent_b, ent_loop;
    logic        is_end, is_ext, reserved, loop_mark, n_loop;
    logic [31:0] pay_new;
    logic        overflow, fin_err, limit_hit;

    logic          we    [PORTS];
    logic [IW-1:0] widx  [PORTS];
    entry_t        wdata [PORTS];
    entry_t        bank_q [MAX_ENT];

    assign base_words  = open_q ? words_q : '0;
    assign base_cnt    = open_q ? cnt_q : '0;
    assign base_ext    = open_q & ext_q;
    assign base_err    = open_q & err_q;
    assign total_words = base_words + WW'(1);

    pfx_word_split u_split (
        .word      (in_word),
        .ext_on    (base_ext),
        .ext_pay   (pay_q),
        .n_new     (n_new),
        .ent_a     (ent_a),
        .ent_b     (ent_b),
        .is_end    (is_end),
        .is_ext    (is_ext),
        .reserved  (reserved),
        .loop_mark (loop_mark),
        .pay       (pay_new)
    );

    pfx_loop_infer #(.WW(WW)) u_loop (
        .total_words (total_words),
        .w0_mark     (w0m_q),
        .w1_mark     (w1m_q),
        .code        (loop_code)
    );

    always_comb begin
        n_loop         = is_end && (loop_code != 2'b00);
        need           = base_cnt + IW'(n_new) + IW'(n_loop);
        overflow       = need > IW'(MAX_ENT);
        fin_err        = base_err | reserved | overflow;
        limit_hit      = !is_end && (total_words == WW'(MAX_WORDS));
        ent_loop       = '0;
        ent_loop.enc   = {30'd0, loop_code};
        ent_loop.kind  = ENT_LOOP;
        we[0]    = in_valid && (n_new != 2'd0);
        widx[0]  = base_cnt;
        wdata[0] = ent_a;
        we[1]    = in_valid && (n_new == 2'd2);
        widx[1]  = base_cnt + IW'(1);
        wdata[1] = ent_b;
        we[2]    = in_valid && n_loop;
        widx[2]  = base_cnt + IW'(n_new);
        wdata[2] = ent_loop;
    end

    pfx_entry_bank #(.N(MAX_ENT), .IW(IW), .PORTS(PORTS)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (we),
        .widx  (widx),
        .wdata (wdata),
        .q     (bank_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q     <= 1'b0;
            ext_q      <= 1'b0;
            err_q      <= 1'b0;
            w0m_q      <= 1'b0;
            w1m_q      <= 1'b0;
            words_q    <= '0;
            cnt_q      <= '0;
            pay_q      <= '0;
            pkt_done   <= 1'b0;
            pkt_status <= ST_IDLE;
            pkt_words  <= '0;
            pkt_bytes  <= '0;
            pkt_count  <= '0;
        end else begin
            pkt_done <= 1'b0;
            if (in_valid) begin
                words_q <= total_words;
                cnt_q   <= base_cnt + IW'(n_new);
                err_q   <= fin_err;
                ext_q   <= is_ext;
                if (is_ext) pay_q <= pay_new;
                if (base_words == WW'(0)) w0m_q <= loop_mark;
                if (base_words == WW'(1)) w1m_q <= loop_mark;
                if (is_end || limit_hit) begin
                    open_q   <= 1'b0;
                    pkt_done <= 1'b1;
                    if (limit_hit) begin
                        pkt_status <= ST_SHORT;
                        pkt_words  <= '0;
                        pkt_bytes  <= '0;
                        pkt_count  <= '0;
                    end else begin
                        pkt_status <= fin_err ? ST_FAULT : ST_OK;
                        pkt_words  <= total_words;
                        pkt_bytes  <= {total_words, 2'b00};
                        pkt_count  <= overflow ? CW'(MAX_ENT) : CW'(need);
                    end
                end else begin
                    open_q <= 1'b1;
                end
            end else if (in_flush && open_q) begin
                open_q     <= 1'b0;
                pkt_done   <= 1'b1;
                pkt_status <= ST_SHORT;
                pkt_words  <= '0;
                pkt_bytes  <= '0;
                pkt_count  <= '0;
            end
        end
    end

    for (genvar g = 0; g < MAX_ENT; g++) begin : g_flat
        assign ent_enc[g*32 +: 32] = bank_q[g].enc;
        assign ent_kind[g*2 +: 2]  = bank_q[g].kind;
        assign ent_ext[g]          = bank_q[g].ext;
        assign ent_imm[g*32 +: 32] = bank_q[g].imm;
    end

    AST_END_CLOSES: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_word[15:14] == 2'b11) |=> pkt_done); // R1
    AST_WORDS_BOUND: assert property (@(posedge clk) disable iff (rst)
        pkt_done |-> (pkt_words <= WW'(MAX_WORDS))); // R1
    AST_DUP_RESERVED: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_word[15:14] == 2'b00 && {in_word[31:29], in_word[13]} == 4'hF)
        |=> (pkt_done && pkt_status == ST_FAULT)); // R3
    AST_SHORT_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (pkt_done && pkt_status == ST_SHORT) |-> (pkt_words == '0 && pkt_count == '0)); // R8
    AST_FLUSH_SHORT: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && in_flush && open_q) |=> (pkt_done && pkt_status == ST_SHORT)); // R8
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        pkt_done |-> (pkt_count <= CW'(MAX_ENT))); // R9

endmodule

// File: tb/vliw_pkt_framer_test.sv
module vliw_pkt_framer_test;
    localparam int NE = 4;
    localparam int NW = 4;
    localparam int WW = $clog2(NW + 1);
    localparam int CW = $clog2(NE + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_flush = 1'b0;
    logic [31:0] in_word = '0;
    logic pkt_done;
    logic [1:0] pkt_status;
    logic [WW-1:0] pkt_words;
    logic [WW+1:0] pkt_bytes;
    logic [CW-1:0] pkt_count;
    logic [NE*32-1:0] ent_enc, ent_imm;
    logic [NE*2-1:0] ent_kind;
    logic [NE-1:0] ent_ext;

    int n_cmp = 0;
    int n_bad = 0;
    string tag = "R10";

    bit exp_done = 0;
    int exp_status, exp_words, exp_count;
    logic [31:0] exp_enc [NE];
    logic [31:0] exp_imm [NE];
    int exp_kind [NE];
    bit exp_ext [NE];
    logic [31:0] pend_q [$];

    vliw_pkt_framer #(.MAX_ENT(NE), .MAX_WORDS(NW)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .in_flush(in_flush), .pkt_done(pkt_done), .pkt_status(pkt_status),
        .pkt_words(pkt_words), .pkt_bytes(pkt_bytes), .pkt_count(pkt_count),
        .ent_enc(ent_enc), .ent_kind(ent_kind), .ent_ext(ent_ext), .ent_imm(ent_imm)
    );

    always #2 clk = ~clk;

    function automatic logic [31:0] mk(input logic [15:0] hi, input logic [1:0] pb,
                                       input logic [13:0] lo);
        return {hi, pb, lo};
    endfunction

    task automatic cmp(input string what, input logic [63:0] act, input logic [63:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, expv);
        end
    endtask

    task automatic model_close(input bit short);
        logic [31:0] e_enc [$];
        logic [31:0] e_imm [$];
        int e_kind [$];
        bit e_ext [$];
        bit err = 0;
        bit have = 0;
        logic [31:0] xv = '0;
        int n, code;
        exp_done = 1;
        if (short) begin
            exp_status = 2; exp_words = 0; exp_count = 0;
            pend_q.delete();
            return;
        end
        foreach (pend_q[j]) begin
            logic [31:0] w;
            logic [31:0] s1, s0;
            w = pend_q[j];
            if (w[15:14] == 2'b00) begin
                if ({w[31:29], w[13]} == 4'hF) err = 1;
                s1 = {19'd0, w[28:16]};
                s0 = {19'd0, w[12:0]};
                e_enc.push_back(s1); e_kind.push_back(1); e_ext.push_back(have);
                e_imm.push_back(have ? (xv | {26'd0, s1[5:0]}) : {26'd0, s1[5:0]});
                have = 0;
                e_enc.push_back(s0); e_kind.push_back(1); e_ext.push_back(0);
                e_imm.push_back({26'd0, s0[5:0]});
            end else if (w[31:28] == 4'h0) begin
                have = 1;
                xv = {w[27:16], w[13:0], 6'd0};
            end else begin
                e_enc.push_back(w); e_kind.push_back(0); e_ext.push_back(have);
                e_imm.push_back(have ? (xv | {26'd0, w[5:0]}) : {26'd0, w[5:0]});
                have = 0;
            end
        end
        n = pend_q.size();
        code = 0;
        if (n == 2 && pend_q[0][15:14] == 2'b10) code = 1;
        if (n >= 3) code = (pend_q[0][15:14] == 2'b10 ? 1 : 0) + (pend_q[1][15:14] == 2'b10 ? 2 : 0);
        if (code != 0) begin
            e_enc.push_back(32'(code)); e_kind.push_back(2); e_ext.push_back(0); e_imm.push_back('0);
        end
        if (e_enc.size() > NE) err = 1;
        exp_status = err ? 3 : 1;
        exp_words = n;
        exp_count = (e_enc.size() > NE) ? NE : e_enc.size();
        for (int j = 0; j < exp_count; j++) begin
            exp_enc[j] = e_enc[j]; exp_imm[j] = e_imm[j];
            exp_kind[j] = e_kind[j]; exp_ext[j] = e_ext[j];
        end
        pend_q.delete();
    endtask

    task automatic check_outputs();
        cmp("R1 done pulse", 64'(pkt_done), 64'(exp_done));
        if (exp_done) begin
            cmp({tag, " status"}, 64'(pkt_status), 64'(exp_status));
            cmp({tag, " words (R1)"}, 64'(pkt_words), 64'(exp_words));
            cmp("R1 bytes", 64'(pkt_bytes), 64'(exp_words * 4));
            cmp({tag, " count"}, 64'(pkt_count), 64'(exp_count));
            for (int j = 0; j < exp_count; j++) begin
                cmp($sformatf("%s enc[%0d]", tag, j), 64'(ent_enc[j*32 +: 32]), 64'(exp_enc[j]));
                cmp($sformatf("%s kind[%0d]", tag, j), 64'(ent_kind[j*2 +: 2]), 64'(exp_kind[j]));
                cmp($sformatf("%s ext[%0d]", tag, j), 64'(ent_ext[j]), 64'(exp_ext[j]));
                cmp($sformatf("%s imm[%0d]", tag, j), 64'(ent_imm[j*32 +: 32]), 64'(exp_imm[j]));
            end
        end
    endtask

    task automatic drive(input bit v, input logic [31:0] w, input bit f);
        @(negedge clk);
        check_outputs();
        in_valid = v; in_word = w; in_flush = f;
        exp_done = 0;
        if (v) begin
            pend_q.push_back(w);
            if (w[15:14] == 2'b11 || w[15:14] == 2'b00) model_close(0);
            else if (pend_q.size() == NW) model_close(1);
        end else if (f && pend_q.size() > 0) begin
            model_close(1);
        end
    endtask

    task automatic idle();
        drive(0, '0, 0);
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL R1 watchdog: actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        cmp("R10 reset done", 64'(pkt_done), 64'd0);
        cmp("R10 reset status", 64'(pkt_status), 64'd0);
        rst = 1'b0;

        tag = "R5";
        drive(1, mk(16'h1234, 2'b11, 14'h0005), 0); idle();
        drive(1, mk(16'h7F00, 2'b01, 14'h00FF), 0);
        drive(1, mk(16'h4100, 2'b11, 14'h2A2A), 0); idle();

        tag = "R6";
        drive(1, mk(16'h2000, 2'b10, 14'h0011), 0);
        drive(1, mk(16'h3000, 2'b11, 14'h0022), 0); idle();

        tag = "R7";
        drive(1, mk(16'h2001, 2'b01, 14'h0001), 0);
        drive(1, mk(16'h2002, 2'b10, 14'h0002), 0);
        drive(1, mk(16'h2003, 2'b11, 14'h0003), 0); idle();
        drive(1, mk(16'h2101, 2'b10, 14'h0001), 0);
        drive(1, mk(16'h2102, 2'b10, 14'h0002), 0);
        drive(1, mk(16'h2103, 2'b11, 14'h0003), 0); idle();
        drive(1, mk(16'h2201, 2'b10, 14'h0001), 0);
        drive(1, mk(16'h2202, 2'b01, 14'h0002), 0);
        drive(1, mk(16'h2203, 2'b11, 14'h0003), 0); idle();

        tag = "R4";
        drive(1, mk(16'h0ABC, 2'b01, 14'h1234), 0);
        drive(1, mk(16'h5000, 2'b11, 14'h003F), 0); idle();
        drive(1, mk(16'h0FFF, 2'b11, 14'h3FFF), 0);
        drive(1, mk(16'h5100, 2'b11, 14'h0007), 0); idle();

        tag = "R2";
        drive(1, mk({3'b010, 13'h1ABC}, 2'b00, {1'b0, 13'h0155}), 0); idle();
        drive(1, mk(16'h0123, 2'b01, 14'h0456), 0);
        drive(1, mk({3'b101, 13'h0A3F}, 2'b00, {1'b1, 13'h1FC1}), 0); idle();

        tag = "R3";
        drive(1, mk({3'b111, 13'h0001}, 2'b00, {1'b1, 13'h0002}), 0); idle();

        tag = "R8";
        drive(1, mk(16'h6000, 2'b01, 14'h0001), 0);
        drive(1, mk(16'h6001, 2'b01, 14'h0002), 0);
        drive(0, '0, 1); idle();
        for (int k = 0; k < NW; k++) drive(1, mk(16'h6100 + 16'(k), 2'b01, 14'(k)), 0);
        idle();
        drive(0, '0, 1); idle();

        tag = "R9";
        for (int k = 0; k < 3; k++) drive(1, mk(16'h7000 + 16'(k), 2'b01, 14'(k)), 0);
        drive(1, mk({3'b001, 13'h0005}, 2'b00, {1'b0, 13'h0009}), 0); idle();
        drive(1, mk(16'h7100, 2'b01, 14'h0001), 0);
        drive(1, mk(16'h7101, 2'b10, 14'h0002), 0);
        drive(1, mk(16'h7102, 2'b01, 14'h0003), 0);
        drive(1, mk(16'h7103, 2'b11, 14'h0004), 0); idle();

        tag = "R1";
        for (int k = 0; k < 4; k++) drive(1, mk(16'h8000 + 16'(k), 2'b11, 14'(k)), 0);
        idle();

        for (int k = 0; k < 600; k++) begin
            bit v;
            bit f;
            v = ($urandom % 5) != 0;
            f = ($urandom % 6) == 0;
            drive(v, $urandom, f);
        end
        idle(); idle();

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule